// File: doc/BRIEF.md
# Programmable Generic Clock Generator

This block drives a bank of generated clock outputs, one per channel. Each channel picks one of four source clocks (two oscillators and two PLL outputs). It then either passes that source straight through or divides it by an even ratio from 2 to 512. Software configures each channel with one 32-bit control word, written and read back through a plain register port: a write strobe, a byte address, write data, and combinational read data.

The sources arrive as square-wave levels that are synchronous to the block clock. Each channel works from the rising edges of its selected source and produces a registered output level. A change to the source, the enable or the divider enable waits until the channel output is low. A new divide value waits for the end of the current half-period. Both rules keep every high and low phase at its full length.

Top module: `gclk_gen`

## Requirements
- R1: After the active-low synchronous reset, every control word reads as zero and every output is low.
- R2: The control word of channel i sits at byte address 0x60 + 4*i, for i = 0..NCH-1 (NCH = 8 by default). A write to any other address changes no channel, and a read from any other address returns zero.
- R3: Bit 0 is the oscillator select, bit 1 the PLL select, bit 2 the clock enable, bit 4 the divider enable, and bits 15:8 the divide value DIV. Bit 3 and all other bits ignore writes and read as zero.
- R4: The source index is {bit1, bit0}: 0 = oscillator 0, 1 = oscillator 1, 2 = PLL 0, 3 = PLL 1 (src_i bit positions 0..3).
- R5: With the enable bit cleared, the output goes low and stays low. Writing an all-zero word stops the channel.
- R6: With the divider enable cleared, the output follows the selected source with a ratio of 1, delayed by one block clock.
- R7: With the divider enable set, the output toggles on every (DIV+1)-th rising edge of the source. This gives a period of 2*(DIV+1) source periods at 50% duty.
- R8: DIV = 255 gives the largest ratio, 512.
- R9: A change of source, enable or divider enable takes effect only while the output is low, so a high phase in progress completes at full length.
- R10: A change of DIV alone is picked up at the next terminal count, so the half-period in progress keeps the old length.
- R11: Channels run independently, each from its own control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the control words |
| reg_addr | input | 12 | Byte address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_i | input | 4 | Source levels: osc0, osc1, pll0, pll1 |
| gclk_o | output | 8 | Generated clock, one bit per channel |

## Verification
The bench builds the block with its defaults: eight channels, a 12-bit address, base 0x60 and stride 4. All eight channel slots can therefore be written and read back, and 0x80, the first address past the top slot, can be probed. The four sources run at different rates, half-periods of 3, 5, 2 and 4 block clocks. This way each select code gives a distinct measured period. The full 8-bit divide field makes the 512 ratio reachable within the run. The reconfiguration tests write a new control word in the middle of a high phase and then measure that phase.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
  localparam int CTRL_W  = 32;
  localparam int DIV_W   = 8;
  localparam int NSRC    = 4;
  localparam int SEL_W   = $clog2(NSRC);
  localparam int B_OSC   = 0;
  localparam int B_PLL   = 1;
  localparam int B_EN    = 2;
  localparam int B_DVEN  = 4;
  localparam int DIV_LSB = 8;

  localparam logic [CTRL_W-1:0] CTRL_MASK =
      (CTRL_W'((1 << DIV_W) - 1) << DIV_LSB) |
      (CTRL_W'(1) << B_DVEN) | (CTRL_W'(1) << B_EN) |
      (CTRL_W'(1) << B_PLL)  | (CTRL_W'(1) << B_OSC);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             dven;
    logic             en;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;
endpackage

// File: rtl/gclk_regs.sv
module gclk_regs
  import gclk_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h60,
  parameter int STRIDE = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [CTRL_W-1:0]      wdata_i,
  output logic [CTRL_W-1:0]      rdata_o,
  output chan_cfg_t [NCH-1:0]    cfg_o
);
  logic [NCH-1:0][CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0]             hit;

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    assign hit[i] = (addr_i == ADDR_W'(BASE + STRIDE * i));

    always_ff @(posedge clk) begin
      if (!rst_n)                ctrl_q[i] <= '0;
      else if (we_i && hit[i])   ctrl_q[i] <= wdata_i & CTRL_MASK;
    end

    assign cfg_o[i].div  = ctrl_q[i][DIV_LSB +: DIV_W];
    assign cfg_o[i].dven = ctrl_q[i][B_DVEN];
    assign cfg_o[i].en   = ctrl_q[i][B_EN];
    assign cfg_o[i].sel  = {ctrl_q[i][B_PLL], ctrl_q[i][B_OSC]};

    // R2: a write to this slot lands in the decoded fields
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && hit[i]) |=> (cfg_o[i].div == $past(wdata_i[DIV_LSB +: DIV_W]))
                        && (cfg_o[i].en == $past(wdata_i[B_EN])));
    // R2: without a write to this slot the word holds
    p_nohit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && hit[i]) |=> $stable(ctrl_q[i]));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (hit[i]) rdata_o = ctrl_q[i];
  end
endmodule

// File: rtl/gclk_chan.sv
module gclk_chan
  import gclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  chan_cfg_t       cfg_i,
  input  logic [NSRC-1:0] src_lvl_i,
  input  logic [NSRC-1:0] src_rise_i,
  output logic            gclk_o
);
  logic [SEL_W-1:0] a_sel;
  logic             a_en;
  logic             a_dven;
  logic [DIV_W-1:0] a_div;
  logic [DIV_W-1:0] cnt;
  logic             gq;
  logic             cfg_diff;

  assign cfg_diff = (cfg_i.sel != a_sel) || (cfg_i.en != a_en) ||
                    (cfg_i.dven != a_dven);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sel  <= '0;
      a_en   <= 1'b0;
      a_dven <= 1'b0;
      a_div  <= '0;
      cnt    <= '0;
      gq     <= 1'b0;
    end else if (!gq && cfg_diff) begin
      a_sel  <= cfg_i.sel;
      a_en   <= cfg_i.en;
      a_dven <= cfg_i.dven;
      a_div  <= cfg_i.div;
      cnt    <= '0;
      gq     <= 1'b0;
    end else if (!a_en) begin
      gq  <= 1'b0;
      cnt <= '0;
    end else if (!a_dven) begin
      gq <= src_lvl_i[a_sel];
    end else if (src_rise_i[a_sel]) begin
      if (cnt == a_div) begin
        gq    <= ~gq;
        cnt   <= '0;
        a_div <= cfg_i.div;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign gclk_o = gq;

  // R9: while the output is high the applied setup may not move
  p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gq |=> ($stable(a_sel) && $stable(a_en) && $stable(a_dven)));
  // R5: a disabled channel drives low on the next cycle
  p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> !gq);
  // R7: the divide counter never passes its terminal value
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= a_div);
  // R10: the divide value moves only when the count restarts
  p_div_at_tc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_div != $past(a_div)) |-> (cnt == '0));
endmodule

// File: rtl/gclk_gen.sv
module gclk_gen
  import gclk_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h60,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        src_i,
  output logic [NCH-1:0]    gclk_o
);
  chan_cfg_t [NCH-1:0] cfg;
  logic [NSRC-1:0]     src_prev;
  logic [NSRC-1:0]     src_rise;

  gclk_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .cfg_o   (cfg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src_i;
  end
  assign src_rise = src_i & ~src_prev;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    gclk_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_i      (cfg[c]),
      .src_lvl_i  (src_i),
      .src_rise_i (src_rise),
      .gclk_o     (gclk_o[c])
    );
  end
endmodule

// File: tb/gclk_gen_test.sv
module gclk_gen_test;
  localparam int NCH = 8;
  localparam int LIM = 6000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  src_i = '0;
  logic [NCH-1:0] gclk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gclk_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_i(src_i), .gclk_o(gclk_o)
  );

  // source half-periods in block clocks: osc0, osc1, pll0, pll1
  localparam int HALF [4] = '{3, 5, 2, 4};
  int scnt [4] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (scnt[k] == HALF[k] - 1) begin
        scnt[k] = 0;
        src_i[k] = ~src_i[k];
      end else scnt[k] = scnt[k] + 1;
    end
  end

  // vector table: channel k gets VEC_CTRL[k]; expected high (= low) length
  localparam logic [31:0] VEC_CTRL [8] =
    '{32'h0004, 32'h0005, 32'h0006, 32'h0007, 32'h0014, 32'h0115, 32'h0316, 32'h0217};
  localparam int VEC_HI [8] = '{3, 5, 2, 4, 6, 20, 16, 24};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 12'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_rise(input int ch);
    int t = 0;
    while (gclk_o[ch] !== 1'b0 && t < LIM) begin @(negedge clk); t++; end
    while (gclk_o[ch] !== 1'b1 && t < LIM) begin @(negedge clk); t++; end
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    hi = 0; lo = 0;
    wait_rise(ch);
    while (gclk_o[ch] === 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
    while (gclk_o[ch] === 1'b0 && lo < LIM) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, lo, ones;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(gclk_o === '0, "R1 outputs low", int'(gclk_o), 0);
    for (int k = 0; k < NCH; k++) begin
      rd('h60 + 4 * k, d);
      check(d === 32'h0, "R1 word zero", int'(d), 0);
    end

    // R3, R4, R6, R7, R11: table walk, reserved bits set on every write
    for (int k = 0; k < NCH; k++) wr('h60 + 4 * k, VEC_CTRL[k] | 32'hFFFF_00E8);
    for (int k = 0; k < NCH; k++) begin
      rd('h60 + 4 * k, d);
      check(d === VEC_CTRL[k], "R3 readback", int'(d), int'(VEC_CTRL[k]));
    end
    for (int k = 0; k < NCH; k++) begin
      measure(k, hi, lo);
      measure(k, hi, lo);
      check(hi == VEC_HI[k], "R4/R6/R7/R11 high", hi, VEC_HI[k]);
      check(lo == VEC_HI[k], "R7 low", lo, VEC_HI[k]);
    end

    // R2: out-of-map addresses
    wr('h80, 32'hFFFF_FFFF);
    wr('h5C, 32'hFFFF_FFFF);
    rd('h80, d);
    check(d === 32'h0, "R2 unmapped read", int'(d), 0);
    rd('h60, d);
    check(d === VEC_CTRL[0], "R2 ch0 untouched", int'(d), int'(VEC_CTRL[0]));
    rd('h7C, d);
    check(d === VEC_CTRL[7], "R2 ch7 untouched", int'(d), int'(VEC_CTRL[7]));

    // R8: largest ratio on pll0 (half 2): period 2048, high 1024
    wr('h64, 32'hFF16);
    measure(1, hi, lo);
    measure(1, hi, lo);
    check(hi == 1024, "R8 high", hi, 1024);
    check(lo == 1024, "R8 low", lo, 1024);

    // R9: source change during a high phase of pll0 div3 (high 16)
    wr('h68, 32'h0316);
    measure(2, hi, lo);
    wait_rise(2);
    reg_we = 1'b1; reg_addr = 12'h68; reg_wdata = 32'h0014;
    hi = 0;
    while (gclk_o[2] === 1'b1 && hi < LIM) begin
      hi++; @(negedge clk); reg_we = 1'b0;
    end
    reg_we = 1'b0;
    check(hi == 16, "R9 high phase kept", hi, 16);
    measure(2, hi, lo);
    measure(2, hi, lo);
    check(hi == 6, "R9 new setup high", hi, 6);

    // R10: DIV change alone during a high phase (old 16, new 4)
    wr('h6C, 32'h0316);
    measure(3, hi, lo);
    wait_rise(3);
    reg_we = 1'b1; reg_addr = 12'h6C; reg_wdata = 32'h0016;
    hi = 0;
    while (gclk_o[3] === 1'b1 && hi < LIM) begin
      hi++; @(negedge clk); reg_we = 1'b0;
    end
    reg_we = 1'b0;
    lo = 0;
    while (gclk_o[3] === 1'b0 && lo < LIM) begin lo++; @(negedge clk); end
    check(hi == 16, "R10 current half kept", hi, 16);
    check(lo == 4, "R10 next half new DIV", lo, 4);

    // R5: all-zero word stops channel 6
    wr('h78, 32'h0);
    repeat (40) @(negedge clk);
    ones = 0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (gclk_o[6] === 1'b1) ones++;
    end
    check(ones == 0, "R5 stopped output", ones, 0);
    // R5: enable cleared with divider bits left on
    wr('h7C, 32'h0213);
    repeat (60) @(negedge clk);
    ones = 0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (gclk_o[7] === 1'b1) ones++;
    end
    check(ones == 0, "R5 enable cleared", ones, 0);
    // R11: channel 5 unaffected by the above
    measure(5, hi, lo);
    check(hi == 20, "R11 ch5 still running", hi, 20);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(gclk_o === '0, "R1 outputs after reset", int'(gclk_o), 0);
    rd('h74, d);
    check(d === 32'h0, "R1 word after reset", int'(d), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule